// File: doc/BRIEF.md
# Timed Burst Writer for a Synchronous Bridge FIFO

This block feeds an external USB bridge chip through the chip's synchronous parallel write port. It runs on the clock that the bridge supplies. A built-in producer makes a fixed-size burst of bytes once per period of `PERIOD_CYCLES` clocks. With the 60 MHz bridge clock and the default period of 60, that is one burst per microsecond. Burst bytes go into a local byte buffer. A writer stage takes bytes from the buffer and presents them on an 8-bit bus with an active-low strobe.

The bridge signals that it can take data by pulling its space flag low. It may raise the flag again after every byte it latches. When its buffers are full, it may keep the flag high for an unbounded time. The writer holds the presented byte until the bridge accepts it, so no byte is lost or sent twice. If the local buffer overflows while the bridge stalls, the bytes that do not fit are discarded and counted. A sticky status bit records that the bridge reported no space at least once.

Top module: `fifo_bridge_streamer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself. After that edge `wr_n` is 1, `drop_count` is 0, `nospace_seen` is 0 and the buffer is empty. The first byte produced after reset carries the value 0x00.
- R2: Every `PERIOD_CYCLES` clocks the producer emits N bytes, one per clock. N is taken from `burst_len` at the start of each period. A value above `MAX_BURST` acts as `MAX_BURST`, and 0 emits no bytes. While `space_n` stays low, every emitted byte is written out, so exactly N bytes per period are accepted.
- R3: Byte values form an 8-bit counter that wraps. It advances by one for every produced byte, including bytes that are dropped.
- R4: A byte is accepted only on a rising edge where both `wr_n` and `space_n` are low. While `wr_n` is low and `space_n` is high, `wr_n` stays low and `wr_data` keeps its value.
- R5: When `space_n` goes high for one cycle after each accepted byte, the accepted sequence still has no missing and no repeated values.
- R6: While `space_n` is held high for many periods, no byte is accepted and `wr_n` stays low on the pending byte. When `space_n` falls again, output resumes in order, starting with that pending byte.
- R7: A produced byte that finds the buffer full is discarded and `drop_count` rises by one. Bytes already stored are not affected. The values missing from the accepted sequence therefore number exactly the increase of `drop_count`, in one contiguous run per overflow episode.
- R8: `drop_count` saturates at all ones (2^`DROP_W` - 1) and then holds that value.
- R9: `nospace_seen` becomes 1 after any clock edge, outside reset, at which `space_n` is high. It stays 1 until it is cleared. It stays 0 while `space_n` is never high.
- R10: If `nospace_clr` is high at an edge where `space_n` is low, `nospace_seen` reads 0 after that edge. If `space_n` is high at that same edge, `nospace_seen` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the bridge |
| rst | input | 1 | Synchronous reset, active high |
| burst_len | input | $clog2(MAX_BURST+1) | Bytes per period, sampled at each period start |
| space_n | input | 1 | Bridge can take a byte when low |
| nospace_clr | input | 1 | Clears the sticky no-space indicator |
| wr_n | output | 1 | Registered write strobe, active low |
| wr_data | output | 8 | Registered byte presented to the bridge |
| nospace_seen | output | 1 | Sticky: the bridge reported no space |
| drop_count | output | DROP_W | Saturating count of bytes lost to buffer overflow |

## Verification
The first pattern holds the space flag low and sweeps the burst length from 0 through 34, plus 63. Counting exact acceptances over whole periods separates a correct burst size from an off-by-one, and shows whether clamping is applied and whether the writer sustains one byte per clock. The second pattern raises the flag for one cycle after every accepted byte, which exposes any loss or duplication in the hold-and-advance logic. The third pattern is a long stall followed by release: the gaps in the accepted values must match the drop counter exactly, which separates correct overflow handling from corruption of stored bytes. A still longer stall then shows saturation. Clears issued while the flag is low and while it is high show the set-over-clear priority of the sticky bit.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // One produced byte travelling from the burst producer to the buffer
    typedef struct packed {
        logic  valid;
        byte_t data;
    } beat_t;

    // Writer stage: either nothing presented, or a byte held on the bus
    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_HOLD = 1'b1
    } wr_state_e;

    // Requested burst size limited to the supported maximum
    function automatic int unsigned clamp_burst(int unsigned req, int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/fbs_burst_gen.sv
module fbs_burst_gen
    import fbs_pkg::*;
#(
    parameter int PERIOD_CYCLES = 60,
    parameter int MAX_BURST     = 32,
    parameter int LEN_W         = $clog2(MAX_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] burst_len,
    output beat_t            beat
);
    localparam int CNT_W = $clog2(PERIOD_CYCLES);

    logic [CNT_W-1:0] phase;
    logic [LEN_W-1:0] remain;
    byte_t            seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            remain <= '0;
            seq    <= '0;
            beat   <= '0;
        end else begin
            phase      <= (phase == CNT_W'(PERIOD_CYCLES - 1)) ? '0 : phase + CNT_W'(1);
            beat.valid <= 1'b0;
            if (phase == '0) begin
                // Burst size is latched once per period
                remain <= LEN_W'(clamp_burst(32'(burst_len), MAX_BURST));
            end else if (remain != '0) begin
                remain     <= remain - LEN_W'(1);
                beat.valid <= 1'b1;
                beat.data  <= seq;
                seq        <= seq + BYTE_W'(1);
            end
        end
    end

endmodule

// File: rtl/fbs_byte_fifo.sv
module fbs_byte_fifo
    import fbs_pkg::*;
#(
    parameter int DEPTH = 64,                 // power of two
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  byte_t            push_data,
    input  logic             pop,
    output byte_t            head,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;
    logic           do_push;
    logic           do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/fbs_tx_writer.sv
module fbs_tx_writer
    import fbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  space_n,
    input  logic  empty,
    input  byte_t head,
    output logic  pop,
    output logic  wr_n,
    output byte_t wr_data
);
    wr_state_e state;
    logic      accept;
    logic      advance;

    // A write completes only when strobe and space flag are both low
    assign accept  = (state == WR_HOLD) && !space_n;
    assign advance = (state == WR_IDLE) || accept;
    assign pop     = advance && !empty;
    assign wr_n    = (state != WR_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WR_IDLE;
            wr_data <= '0;
        end else if (advance) begin
            state <= empty ? WR_IDLE : WR_HOLD;
            if (!empty) begin
                wr_data <= head;
            end
        end
    end

endmodule

// File: rtl/fbs_status.sv
module fbs_status #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop_evt,
    input  logic              space_n,
    input  logic              nospace_clr,
    output logic [DROP_W-1:0] drop_count,
    output logic              nospace_seen
);
    localparam logic [DROP_W-1:0] SAT = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_count <= '0;
        end else if (drop_evt && (drop_count != SAT)) begin
            drop_count <= drop_count + DROP_W'(1);
        end
    end

    // Setting wins over clearing so a concurrent no-space report is kept
    always_ff @(posedge clk) begin
        if (rst) begin
            nospace_seen <= 1'b0;
        end else if (space_n) begin
            nospace_seen <= 1'b1;
        end else if (nospace_clr) begin
            nospace_seen <= 1'b0;
        end
    end

endmodule

// File: rtl/fifo_bridge_streamer.sv
module fifo_bridge_streamer
    import fbs_pkg::*;
#(
    parameter int PERIOD_CYCLES = 60,
    parameter int MAX_BURST     = 32,
    parameter int BUF_DEPTH     = 64,
    parameter int DROP_W        = 16,
    localparam int LEN_W        = $clog2(MAX_BURST + 1),
    localparam int LVL_W        = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic              space_n,
    input  logic              nospace_clr,
    output logic              wr_n,
    output logic [7:0]        wr_data,
    output logic              nospace_seen,
    output logic [DROP_W-1:0] drop_count
);
    beat_t            beat;
    byte_t            head;
    logic             buf_empty;
    logic             buf_full;
    logic             pop;
    logic [LVL_W-1:0] fifo_level;

    fbs_burst_gen #(
        .PERIOD_CYCLES (PERIOD_CYCLES),
        .MAX_BURST     (MAX_BURST),
        .LEN_W         (LEN_W)
    ) u_gen (
        .clk       (clk),
        .rst       (rst),
        .burst_len (burst_len),
        .beat      (beat)
    );

    fbs_byte_fifo #(
        .DEPTH (BUF_DEPTH),
        .LVL_W (LVL_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (beat.valid),
        .push_data (beat.data),
        .pop       (pop),
        .head      (head),
        .empty     (buf_empty),
        .full      (buf_full),
        .level     (fifo_level)
    );

    fbs_tx_writer u_wr (
        .clk     (clk),
        .rst     (rst),
        .space_n (space_n),
        .empty   (buf_empty),
        .head    (head),
        .pop     (pop),
        .wr_n    (wr_n),
        .wr_data (wr_data)
    );

    fbs_status #(
        .DROP_W (DROP_W)
    ) u_stat (
        .clk          (clk),
        .rst          (rst),
        .drop_evt     (beat.valid && buf_full),
        .space_n      (space_n),
        .nospace_clr  (nospace_clr),
        .drop_count   (drop_count),
        .nospace_seen (nospace_seen)
    );

endmodule

// File: rtl/fifo_bridge_streamer_chk.sv
module fifo_bridge_streamer_chk #(
    parameter int BUF_DEPTH = 64,
    parameter int DROP_W    = 16,
    localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              space_n,
    input logic              nospace_clr,
    input logic              wr_n,
    input logic [7:0]        wr_data,
    input logic              nospace_seen,
    input logic [DROP_W-1:0] drop_count,
    input logic [LVL_W-1:0]  fifo_level
);
    localparam logic [DROP_W-1:0] SAT = '1;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (wr_n && (drop_count == '0) && !nospace_seen && (fifo_level == '0)));

    assert_hold_on_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && space_n) |=> (!wr_n && $stable(wr_data)));

    assert_drop_step_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((drop_count == $past(drop_count)) ||
                  (drop_count == $past(drop_count) + DROP_W'(1))));

    assert_no_overfill_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(BUF_DEPTH));

    assert_drop_saturate_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_count == SAT) |=> (drop_count == SAT));

    assert_sticky_set_R9: assert property (@(posedge clk) disable iff (rst)
        space_n |=> nospace_seen);

    assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (nospace_seen && !nospace_clr) |=> nospace_seen);

    assert_sticky_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (nospace_clr && !space_n) |=> !nospace_seen);

endmodule

bind fifo_bridge_streamer fifo_bridge_streamer_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .DROP_W    (DROP_W)
) u_chk (.*);

// File: tb/fifo_bridge_streamer_tb.sv
module fifo_bridge_streamer_tb;
    localparam int PERIOD = 60;
    localparam int MAXB   = 32;
    localparam int DEPTH  = 64;
    localparam int DW     = 8;
    localparam int LEN_W  = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LEN_W-1:0] burst_len = LEN_W'(32);
    logic             space_n = 1'b0;
    logic             nospace_clr = 1'b0;
    logic             wr_n;
    logic [7:0]       wr_data;
    logic             nospace_seen;
    logic [DW-1:0]    drop_count;

    always #2 clk = ~clk;   // 250 MHz

    fifo_bridge_streamer #(
        .PERIOD_CYCLES (PERIOD),
        .MAX_BURST     (MAXB),
        .BUF_DEPTH     (DEPTH),
        .DROP_W        (DW)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .burst_len    (burst_len),
        .space_n      (space_n),
        .nospace_clr  (nospace_clr),
        .wr_n         (wr_n),
        .wr_data      (wr_data),
        .nospace_seen (nospace_seen),
        .drop_count   (drop_count)
    );

    int checks = 0;
    int fails  = 0;

    // Bridge model and acceptance monitor state
    int         mode = 0;        // 0: space low, 1: high after each byte, 2: held high
    bit         pend = 1'b0;
    int         gap_mode = 0;    // 0: any gap is an error, 1: gaps accumulate, 2: ignore
    logic [7:0] exp_val = 8'd0;
    int         acc_cnt = 0;
    int         seq_err = 0;
    int         gap_total = 0;
    int         gap_events = 0;
    int         idle_run = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin : bridge_model
        // Drive the space flag for the coming edge first, then judge acceptance
        case (mode)
            0: space_n = 1'b0;
            2: space_n = 1'b1;
            default: begin
                space_n = pend;
                pend    = 1'b0;
            end
        endcase
        if (!rst && !wr_n && !space_n) begin
            acc_cnt++;
            if (wr_data != exp_val) begin
                if (gap_mode == 1) begin
                    gap_total += int'(8'(wr_data - exp_val));
                    gap_events++;
                end else if (gap_mode == 0) begin
                    seq_err++;
                end
            end
            exp_val = wr_data + 8'd1;
            if (mode == 1) pend = 1'b1;
        end
        idle_run = wr_n ? idle_run + 1 : 0;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (idle_run < 10) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (120000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int c0;
        int d0;
        int e0;
        int nb;

        // R1: reset state
        cycles(3);
        check(wr_n == 1'b1, "R1", "wr_n in reset", wr_n, 1);
        check(drop_count == '0, "R1", "drop_count in reset", drop_count, 0);
        check(nospace_seen == 1'b0, "R1", "nospace_seen in reset", nospace_seen, 0);
        rst = 1'b0;

        // R2 and R3: burst length sweep with the bridge always ready
        for (int n = 0; n <= 35; n++) begin
            nb = (n == 35) ? 63 : n;
            burst_len = LEN_W'(nb);
            cycles(PERIOD + 5);
            wait_idle();
            c0 = acc_cnt;
            cycles(3 * PERIOD);
            check(acc_cnt - c0 == 3 * ((nb > MAXB) ? MAXB : nb), "R2",
                  $sformatf("bytes in 3 periods, burst_len=%0d", nb),
                  acc_cnt - c0, 3 * ((nb > MAXB) ? MAXB : nb));
        end
        check(seq_err == 0, "R3", "sequence errors in sweep", seq_err, 0);
        check(drop_count == '0, "R7", "drops with ready bridge", drop_count, 0);
        check(nospace_seen == 1'b0, "R9", "sticky without any busy cycle", nospace_seen, 0);

        // R5: space flag deasserted for one cycle after every accepted byte
        burst_len = LEN_W'(32);
        cycles(PERIOD);
        c0 = acc_cnt;
        mode = 1;
        cycles(8 * PERIOD);
        mode = 0;
        cycles(3 * PERIOD);
        check(seq_err == 0, "R5", "sequence errors under per-byte toggling", seq_err, 0);
        check(drop_count == '0, "R5", "drops under per-byte toggling", drop_count, 0);
        check((acc_cnt - c0 >= 10 * MAXB) && (acc_cnt - c0 <= 12 * MAXB), "R5",
              "bytes over 11 periods", acc_cnt - c0, 11 * MAXB);
        check(nospace_seen == 1'b1, "R9", "sticky after busy cycles", nospace_seen, 1);

        // R10: clear while the space flag is high keeps the bit set
        mode = 2;
        cycles(2);
        nospace_clr = 1'b1;
        cycles(1);
        nospace_clr = 1'b0;
        check(nospace_seen == 1'b1, "R10", "clear while busy", nospace_seen, 1);
        mode = 0;
        cycles(3);
        check(nospace_seen == 1'b1, "R9", "sticky persists after busy ends", nospace_seen, 1);
        nospace_clr = 1'b1;
        cycles(1);
        nospace_clr = 1'b0;
        check(nospace_seen == 1'b0, "R10", "clear while ready", nospace_seen, 0);
        cycles(PERIOD);

        // R6 and R7: long stall, overflow, release
        gap_mode = 1;
        gap_total = 0;
        gap_events = 0;
        d0 = int'(drop_count);
        e0 = seq_err;
        mode = 2;
        cycles(2);
        c0 = acc_cnt;
        cycles(5 * PERIOD);
        check(acc_cnt == c0, "R6", "bytes accepted during stall", acc_cnt - c0, 0);
        check(wr_n == 1'b0, "R6", "strobe held on pending byte", wr_n, 0);
        check(drop_count != '0, "R7", "drops after overflow", drop_count, 1);
        mode = 0;
        cycles(4 * PERIOD);
        check(gap_total == int'(drop_count) - d0, "R7", "missing values vs drop count",
              gap_total, int'(drop_count) - d0);
        check(gap_events == 1, "R7", "contiguous gap runs", gap_events, 1);
        check(seq_err == e0, "R6", "order after release", seq_err - e0, 0);

        // R8: saturation of the drop counter
        gap_mode = 2;
        mode = 2;
        cycles(14 * PERIOD);
        check(drop_count == '1, "R8", "drop_count saturated", drop_count, 255);
        cycles(2 * PERIOD);
        check(drop_count == '1, "R8", "drop_count holds at saturation", drop_count, 255);
        mode = 0;
        cycles(3);

        // R1: reset during operation, sequence restarts at zero
        rst = 1'b1;
        cycles(2);
        check(wr_n == 1'b1, "R1", "wr_n after mid-run reset", wr_n, 1);
        check(drop_count == '0, "R1", "drop_count after mid-run reset", drop_count, 0);
        check(nospace_seen == 1'b0, "R1", "sticky after mid-run reset", nospace_seen, 0);
        exp_val = 8'd0;
        gap_mode = 0;
        e0 = seq_err;
        c0 = acc_cnt;
        rst = 1'b0;
        cycles(3 * PERIOD);
        check(seq_err == e0, "R1", "first bytes after reset start at zero", seq_err - e0, 0);
        check(acc_cnt - c0 >= 2 * MAXB, "R1", "bytes after reset", acc_cnt - c0, 3 * MAXB);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule